// File: doc/BRIEF.md
# HDLC Transmit Framer with Programmable Interframe Fill

This block frames a byte stream into a single serial HDLC transmit line. Frames arrive over a byte interface with valid, ready and last. The block opens each frame with a programmable minimum number of flag octets and then shifts out the payload. It follows the payload with a complemented frame check of either 16 or 32 bits and a closing flag. Payload and check bits are bit-stuffed. Flags and idle octets are not.

Between frames the line carries one of two fills, chosen by a configuration input. In shared-flag fill, the gap holds nothing but flags. In idle fill, the gap holds at least one all-ones octet, even when the next frame is already waiting, and the opening flags come only once a frame is ready. One bit leaves per bit period, marked by a one-cycle strobe. The configuration inputs only matter in a gap: a change made while a frame is in progress applies from the next gap.

Top module: `hdlc_fill_tx`

## Requirements
- R1: With flag count setting N on `cfgMinFlags` (0 to 7), every frame is preceded by at least N+1 flag octets (0x7E). In idle fill, exactly N+1 flags stand between the last idle octet and the first payload bit.
- R2: With `cfgIdleFill` = 0, no all-ones octet appears on the line. While no frame is offered, the line carries back-to-back flags.
- R3: With `cfgIdleFill` = 1, at least one idle octet is sent after reset before the first frame, and between any two frames, even when the next frame is already offered.
- R4: An idle octet is 0xFF, so every run of seven or more ones on the line is a whole number of octets long. `lineBit` holds 1 during reset and until the first strobed bit.
- R5: Inside the payload and the check field, a 0 is inserted after every five consecutive 1s, including across the boundary into the closing flag. Flags and idle octets are sent unstuffed.
- R6: Octets are sent least significant bit first. The payload octets arrive unchanged and in order, and each frame is closed by a flag directly after its check field.
- R7: `cfgCrc32` = 0 selects the 16-bit CCITT check (reflected polynomial 0x8408, preset 0xFFFF). `cfgCrc32` = 1 selects the 32-bit check (reflected polynomial 0xEDB88320, preset 0xFFFFFFFF). The check is sent complemented, low octet first.
- R8: The configuration is taken at the moment a frame is committed in the gap. Changes while that frame is being sent do not affect its flags or check type.
- R9: `inReady` is high for exactly the cycles in which a payload octet is taken, and only while a frame is being sent. The source keeps `inValid` high from the first octet to the `inLast` octet.
- R10: `lineBitEn` pulses for one cycle every BIT_DIV clock cycles, and `lineBit` carries the new bit in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgIdleFill | input | 1 | 1 selects idle (0xFF) fill between frames, 0 selects shared flags |
| cfgMinFlags | input | 3 | Flag count setting N; at least N+1 opening flags |
| cfgCrc32 | input | 1 | 0 selects the 16-bit check, 1 selects the 32-bit check |
| inData | input | 8 | Payload octet |
| inValid | input | 1 | Payload octet valid |
| inLast | input | 1 | Marks the final payload octet of a frame |
| inReady | output | 1 | Octet taken this cycle when valid |
| lineBit | output | 1 | Serial line bit |
| lineBitEn | output | 1 | Strobe marking a new line bit |

## Verification
The bench decodes the line back into flags, idle runs and destuffed frames. This lets it attack the spots where a framer goes wrong. Payloads rich in 0xFF force stuffing at octet boundaries and just before the closing flag; a missing stuff bit shows up as a false flag that cuts the frame short. Back-to-back frames in idle fill expose a design that skips the mandatory idle octet. Exact flag counts after an idle run catch an off-by-one in the N+1 rule. Each frame also changes the configuration in mid-flight, so a framer that samples its check type or flag count too late closes the frame with the wrong check length.

// File: rtl/hdlc_fill_pkg.sv
package hdlc_fill_pkg;
  localparam int OCTET_W = 8;
  localparam int CHK_W = 32;
  localparam logic [7:0] FLAG_OCTET = 8'h7E;
  localparam logic [7:0] IDLE_OCTET = 8'hFF;
  localparam logic [15:0] POLY16 = 16'h8408;
  localparam logic [31:0] POLY32 = 32'hEDB88320;

  typedef enum logic [1:0] {ST_FILL, ST_OPEN, ST_DATA, ST_CRC} txState_t;

  // strobes from control to datapath, valid in the cycle needLoad is high
  typedef struct packed {
    logic               load;
    logic               loadCrc;
    logic [OCTET_W-1:0] octet;
    logic               stuffOn;
    logic               crcOn;
    logic               crcInit;
    logic               crc32;
  } dpCmd_t;
endpackage

// File: rtl/hdlc_fill_dp.sv
module hdlc_fill_dp
  import hdlc_fill_pkg::*;
#(
  parameter int BIT_DIV = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  dpCmd_t cmd,
  output logic   needLoad,
  output logic   lineBit,
  output logic   lineBitEn
);
  localparam int LEN_W = $clog2(CHK_W + 1);
  localparam int RUN_W = 3;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(5);

  logic             tick;
  logic [CHK_W-1:0] shReg;
  logic [LEN_W-1:0] bitsLeft;
  logic [RUN_W-1:0] onesRun;
  logic             curStuff, curCrc;
  logic [CHK_W-1:0] crcQ;
  logic             stuffNow;
  logic             seenBit;

  generate
    if (BIT_DIV > 1) begin : g_div
      localparam int DIV_W = $clog2(BIT_DIV);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (rst || divCnt == DIV_W'(BIT_DIV - 1)) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign tick = (divCnt == DIV_W'(BIT_DIV - 1));
      // no two strobes in adjacent cycles
      AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
        lineBitEn |=> !lineBitEn); // R10
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  assign stuffNow = (onesRun == RUN_MAX);
  assign needLoad = tick && !stuffNow && (bitsLeft == '0);

  // next content: either the current shifter or freshly loaded material
  logic [CHK_W-1:0] srcVal;
  logic [LEN_W-1:0] srcLen;
  logic             srcStuff, srcCrc;
  always_comb begin
    srcVal   = shReg;
    srcLen   = bitsLeft;
    srcStuff = curStuff;
    srcCrc   = curCrc;
    if (needLoad && cmd.load) begin
      srcStuff = cmd.stuffOn;
      srcCrc   = cmd.crcOn;
      if (cmd.loadCrc) begin
        srcVal = cmd.crc32 ? ~crcQ : {16'h0000, ~crcQ[15:0]};
        srcLen = cmd.crc32 ? LEN_W'(32) : LEN_W'(16);
      end else begin
        srcVal = {{(CHK_W - OCTET_W){1'b0}}, cmd.octet};
        srcLen = LEN_W'(OCTET_W);
      end
    end
  end

  // serial frame check update, one bit per step
  logic [CHK_W-1:0] crcBase, crcNext;
  logic             fb;
  always_comb begin
    crcBase = (needLoad && cmd.load && cmd.crcInit) ? '1 : crcQ;
    fb      = crcBase[0] ^ srcVal[0];
    if (cmd.crc32) crcNext = (crcBase >> 1) ^ (fb ? POLY32 : '0);
    else crcNext = {16'h0000, (crcBase[15:0] >> 1) ^ (fb ? POLY16 : 16'h0000)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lineBit   <= 1'b1;
      lineBitEn <= 1'b0;
      shReg     <= '0;
      bitsLeft  <= '0;
      onesRun   <= '0;
      curStuff  <= 1'b0;
      curCrc    <= 1'b0;
      crcQ      <= '1;
      seenBit   <= 1'b0;
    end else begin
      lineBitEn <= tick;
      if (tick) begin
        seenBit <= 1'b1;
        if (stuffNow) begin
          lineBit <= 1'b0;
          onesRun <= '0;
        end else begin
          lineBit  <= srcVal[0];
          shReg    <= srcVal >> 1;
          bitsLeft <= srcLen - LEN_W'(1);
          curStuff <= srcStuff;
          curCrc   <= srcCrc;
          onesRun  <= (srcStuff && srcVal[0]) ? onesRun + RUN_W'(1) : '0;
          if (srcCrc) crcQ <= crcNext;
        end
      end
    end
  end

  AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && onesRun == RUN_MAX) |=> (lineBitEn && lineBit == 1'b0)); // R5
  AST_RESET_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!seenBit) |-> (lineBit == 1'b1)); // R4
endmodule

// File: rtl/hdlc_fill_ctrl.sv
module hdlc_fill_ctrl
  import hdlc_fill_pkg::*;
#(
  parameter int FLAG_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgIdleFill,
  input  logic [FLAG_W-1:0]  cfgMinFlags,
  input  logic               cfgCrc32,
  input  logic [OCTET_W-1:0] inData,
  input  logic               inValid,
  input  logic               inLast,
  input  logic               needLoad,
  output logic               inReady,
  output dpCmd_t             cmd
);
  txState_t          state;
  logic [FLAG_W-1:0] flagLeft;
  logic              fillSent;
  logic              lastTaken;
  logic              crc32Q;
  logic              startOk;

  // a frame may start once an idle octet went out, or at once in flag fill
  assign startOk = inValid && (!cfgIdleFill || fillSent);
  assign inReady = needLoad &&
                   ((state == ST_OPEN && flagLeft == '0) ||
                    (state == ST_DATA && !lastTaken));

  always_comb begin
    cmd         = '0;
    cmd.load    = needLoad;
    cmd.crc32   = crc32Q;
    cmd.octet   = FLAG_OCTET;
    unique case (state)
      ST_FILL: if (!startOk) cmd.octet = cfgIdleFill ? IDLE_OCTET : FLAG_OCTET;
      ST_OPEN: if (flagLeft == '0) begin
        cmd.octet   = inData;
        cmd.stuffOn = 1'b1;
        cmd.crcOn   = 1'b1;
        cmd.crcInit = 1'b1;
      end
      ST_DATA: begin
        cmd.stuffOn = 1'b1;
        if (lastTaken) cmd.loadCrc = 1'b1;
        else begin
          cmd.octet = inData;
          cmd.crcOn = 1'b1;
        end
      end
      ST_CRC: cmd.octet = FLAG_OCTET;
      default: cmd.octet = FLAG_OCTET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || (needLoad && state == ST_FILL)) crc32Q <= cfgCrc32;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FILL;
      flagLeft  <= '0;
      fillSent  <= 1'b0;
      lastTaken <= 1'b0;
    end else if (needLoad) begin
      unique case (state)
        ST_FILL: begin
          if (startOk) begin
            state    <= ST_OPEN;
            flagLeft <= cfgMinFlags;
          end else begin
            fillSent <= fillSent | cfgIdleFill;
          end
        end
        ST_OPEN: begin
          if (flagLeft != '0) flagLeft <= flagLeft - 1'b1;
          else begin
            state     <= ST_DATA;
            lastTaken <= inLast;
          end
        end
        ST_DATA: begin
          if (lastTaken) state <= ST_CRC;
          else lastTaken <= inLast;
        end
        ST_CRC: begin
          state    <= ST_FILL;
          fillSent <= 1'b0;
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  AST_OPEN_MIN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OPEN && needLoad && flagLeft != '0) |=> (state == ST_OPEN)); // R1
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL && needLoad && cfgIdleFill && !fillSent) |=> (state == ST_FILL)); // R3
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (state != ST_FILL) |=> $stable(crc32Q)); // R8
  AST_READY_VALID: assert property (@(posedge clk) disable iff (rst)
    inReady |-> inValid); // R9
endmodule

// File: rtl/hdlc_fill_tx.sv
module hdlc_fill_tx
  import hdlc_fill_pkg::*;
#(
  parameter int BIT_DIV = 2,
  parameter int FLAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgIdleFill,
  input  logic [FLAG_W-1:0] cfgMinFlags,
  input  logic              cfgCrc32,
  input  logic [7:0]        inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              lineBit,
  output logic              lineBitEn
);
  dpCmd_t cmd;
  logic   needLoad;

  hdlc_fill_ctrl #(.FLAG_W(FLAG_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cfgIdleFill(cfgIdleFill), .cfgMinFlags(cfgMinFlags), .cfgCrc32(cfgCrc32),
    .inData(inData), .inValid(inValid), .inLast(inLast),
    .needLoad(needLoad), .inReady(inReady), .cmd(cmd)
  );

  hdlc_fill_dp #(.BIT_DIV(BIT_DIV)) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd),
    .needLoad(needLoad), .lineBit(lineBit), .lineBitEn(lineBitEn)
  );
endmodule

// File: tb/hdlc_fill_tx_bench.sv
module hdlc_fill_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_DIV    = 2;
  localparam int NUM_FRAMES = 24;
  localparam int MAX_LEN    = 12;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfgIdleFill = 1'b0;
  logic [2:0] cfgMinFlags = 3'd0;
  logic       cfgCrc32 = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;
  logic       inReady, lineBit, lineBitEn;

  hdlc_fill_tx #(.BIT_DIV(BIT_DIV), .FLAG_W(3)) u_hdlc_fill_tx (
    .clk(clk), .rst(rst), .cfgIdleFill(cfgIdleFill), .cfgMinFlags(cfgMinFlags),
    .cfgCrc32(cfgCrc32), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .lineBit(lineBit), .lineBitEn(lineBitEn)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // frames to send
  logic [7:0] sentData [NUM_FRAMES][MAX_LEN];
  int         sentLen  [NUM_FRAMES];
  bit         sentIdle [NUM_FRAMES];
  bit         sentC32  [NUM_FRAMES];
  int         sentNof  [NUM_FRAMES];
  int         sentGap  [NUM_FRAMES];

  function automatic logic [31:0] ref_crc(input int k);
    logic [31:0] c;
    c = sentC32[k] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    for (int i = 0; i < sentLen[k]; i++) begin
      c = c ^ {24'h0, sentData[k][i]};
      for (int j = 0; j < 8; j++)
        c = c[0] ? ((c >> 1) ^ (sentC32[k] ? 32'hEDB8_8320 : 32'h0000_8408)) : (c >> 1);
    end
    return sentC32[k] ? ~c : {16'h0, ~c[15:0]};
  endfunction

  // line decoder state
  int onesRun = 0;
  int accLen = 0;
  bit accBits [0:2047];
  int flagRun = 0;
  bit idleSeen = 1'b0;
  int rxIdx = 0;

  function automatic logic [7:0] acc_byte(input int i);
    logic [7:0] v;
    for (int j = 0; j < 8; j++) v[j] = accBits[i * 8 + j];
    return v;
  endfunction

  task automatic frame_end();
    int k, crcBytes, expLen, badIdx;
    logic [31:0] gotCrc, expCrc;
    k = rxIdx;
    if (k >= NUM_FRAMES) begin
      check(1'b0, "R6", "unexpected extra frame", k, NUM_FRAMES);
      return;
    end
    crcBytes = sentC32[k] ? 4 : 2;
    expLen = sentLen[k] + crcBytes;
    // R8: check length reflects configuration at frame start
    check(accLen == expLen * 8, "R6 R8", "frame bit length", accLen, expLen * 8);
    if (accLen == expLen * 8) begin
      badIdx = -1;
      for (int i = 0; i < sentLen[k]; i++)
        if (badIdx < 0 && acc_byte(i) != sentData[k][i]) badIdx = i;
      check(badIdx < 0, "R6 R5", "payload octet",
            badIdx < 0 ? 0 : acc_byte(badIdx), badIdx < 0 ? 0 : sentData[k][badIdx]);
      gotCrc = '0;
      for (int i = 0; i < crcBytes; i++) gotCrc[i * 8 +: 8] = acc_byte(sentLen[k] + i);
      expCrc = ref_crc(k);
      check(gotCrc == expCrc, "R7 R8", "frame check", gotCrc, expCrc);
    end
    if (sentIdle[k]) begin
      check(flagRun == sentNof[k] + 1, "R1 R8", "flags after idle", flagRun, sentNof[k] + 1);
      check(idleSeen, "R3", "idle octet before frame", idleSeen, 1);
    end else begin
      check(flagRun >= sentNof[k] + 1, "R1 R8", "opening flags", flagRun, sentNof[k] + 1);
      check(!idleSeen, "R2", "idle in flag fill", idleSeen, 0);
    end
    rxIdx++;
    flagRun = 1;
    idleSeen = 1'b0;
  endtask

  task automatic rx_bit(input bit b);
    if (b) begin
      onesRun++;
      if (onesRun == 7) begin
        idleSeen = 1'b1;
        flagRun = 0;
        accLen = 0;
      end else if (onesRun < 7 && accLen < 2048) begin
        accBits[accLen] = 1'b1;
        accLen++;
      end
    end else begin
      if (onesRun >= 7)
        check(onesRun % 8 == 0, "R4", "idle run length", onesRun, (onesRun / 8) * 8);
      if (onesRun == 5) begin
        // inserted zero, dropped
      end else if (onesRun == 6) begin
        accLen -= 7;
        if (accLen > 0) frame_end();
        else flagRun++;
        accLen = 0;
      end else if (accLen < 2048) begin
        accBits[accLen] = 1'b0;
        accLen++;
      end
      onesRun = 0;
    end
  endtask

  int readyBad = 0;
  int strobeBad = 0;
  int sinceBit = 0;
  bit anyBit = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (inReady && !inValid) readyBad++;
      sinceBit++;
      if (lineBitEn) begin
        if (anyBit && sinceBit != BIT_DIV) strobeBad++;
        anyBit = 1'b1;
        sinceBit = 0;
        rx_bit(lineBit);
      end
    end
  end

  task automatic apply_cfg(input int k);
    cfgIdleFill = sentIdle[k];
    cfgMinFlags = 3'(sentNof[k]);
    cfgCrc32 = sentC32[k];
  endtask

  task automatic build_frames();
    void'($urandom(32'h1D1E_F11B));
    for (int k = 0; k < NUM_FRAMES; k++) begin
      sentLen[k] = $urandom_range(1, MAX_LEN);
      sentIdle[k] = $urandom_range(0, 1);
      sentC32[k] = $urandom_range(0, 1);
      sentNof[k] = $urandom_range(0, 7);
      sentGap[k] = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, 80);
      for (int i = 0; i < MAX_LEN; i++)
        sentData[k][i] = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
    end
    // directed: idle fill, N=1, frame waiting from reset
    sentIdle[0] = 1; sentNof[0] = 1; sentC32[0] = 0; sentGap[0] = 0; sentLen[0] = 3;
    // directed: idle fill back to back, N=7, all ones payload, 32-bit check
    sentIdle[1] = 1; sentNof[1] = 7; sentC32[1] = 1; sentGap[1] = 0; sentLen[1] = 5;
    for (int i = 0; i < MAX_LEN; i++) sentData[1][i] = 8'hFF;
    // directed: flag fill, N=0, flag-like payload, waiting gap
    sentIdle[2] = 0; sentNof[2] = 0; sentC32[2] = 0; sentGap[2] = 40; sentLen[2] = 4;
    sentData[2][0] = 8'h7E; sentData[2][1] = 8'h3F; sentData[2][2] = 8'hFC; sentData[2][3] = 8'h1F;
    // directed: flag fill back to back, N=7, check type changes
    sentIdle[3] = 0; sentNof[3] = 7; sentC32[3] = 1; sentGap[3] = 0; sentLen[3] = 1;
    sentData[3][0] = 8'hF8;
  endtask

  initial begin
    build_frames();
    apply_cfg(0);
    repeat (4) @(negedge clk);
    check(lineBit == 1'b1, "R4", "line level in reset", lineBit, 1);
    check(lineBitEn == 1'b0, "R10", "strobe in reset", lineBitEn, 0);
    check(inReady == 1'b0, "R9", "ready in reset", inReady, 0);
    rst = 1'b0;
    @(negedge clk);
    check(lineBit == 1'b1, "R4", "line level after reset", lineBit, 1);
    for (int k = 0; k < NUM_FRAMES; k++) begin
      repeat (sentGap[k]) @(negedge clk);
      for (int b = 0; b < sentLen[k]; b++) begin
        inValid = 1'b1;
        inData = sentData[k][b];
        inLast = (b == sentLen[k] - 1);
        while (!inReady) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        // mid-frame configuration change belongs to the next frame
        if (b == 0 && k + 1 < NUM_FRAMES) apply_cfg(k + 1);
      end
      inValid = 1'b0;
      inLast = 1'b0;
    end
    while (rxIdx < NUM_FRAMES) @(negedge clk);
    repeat (200) @(negedge clk);
    check(rxIdx == NUM_FRAMES, "R6", "frames decoded", rxIdx, NUM_FRAMES);
    check(readyBad == 0, "R9", "ready without a pending octet", readyBad, 0);
    check(strobeBad == 0, "R10", "strobe spacing errors", strobeBad, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d frames expected %0d", rxIdx, NUM_FRAMES);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule